// File: doc/BRIEF.md
# Two-Wire Serial Avionics Word Receiver with Label Filter

The block receives 32-bit avionics data words from a pair of already-thresholded line inputs, A and B. Each bit is a return-to-zero symbol. A high on A alone is a one, a high on B alone is a zero, and both low is the null level between bits. The decoder assembles the bits in arrival order and rejects badly framed words. A word is rejected when the frame breaks off in a long null gap, or when both lines are high at any point in it.

A complete, well-formed word is then sorted. Its label byte is compared against three programmable priority labels. A word that hits one of them skips the main queue and lands in that label's two-deep holding slot. Any other word is kept only if its label is enabled in a 256-entry acceptance table. Kept words go into a 32-word queue, which the host reads in first-in, first-out order. A label bit-reversal option changes only how the label appears in queued words. Bit 32 can be checked as odd parity or passed through as plain data. A one-cycle pulse marks each stored word.

Top module: `a429_label_rx`

## Requirements
- R1: After reset, `fifo_empty`=1, `fifo_full`=0, `fifo_overflow`=0, `prio_ready`=0 and `word_irq`=0.
- R2: A line symbol with A high and B low is a one, and B high with A low is a zero; a bit is taken when the lines leave null. Bit 1 is received first. A stored word has bit 32 at [31], bits 31 down to 9 at [30:8], and the label byte at [7:0], with bit 1 as the label MSB at [7] and bit 8 at [0].
- R3: With `cfg_label_flip`=1, a queued word carries its label byte bit-reversed (bit 1 at [0]). The table lookup, the priority comparison and the label held in the priority slots always use the unreversed label.
- R4: A word that hits no priority label is queued only if its table entry is 1. Entry L is written through `tbl_we`/`tbl_addr`/`tbl_bit`, where L is the unreversed label. A word whose entry is 0 leaves the queue empty and raises no pulse.
- R5: With `cfg_parity_en`=1, a word with an even count of ones over all 32 bits is discarded. With `cfg_parity_en`=0, the same word is stored unchanged.
- R6: If null lasts `GAP_CYC` clocks after 1 to 31 bits of a word, the partial word is dropped and the next word is decoded from its bit 1.
- R7: A word during which both lines were high at the same time is discarded even when 32 bits were counted. The following word is unaffected.
- R8: The queue holds `FIFO_DEPTH` (32) words in arrival order and raises `fifo_full` when it is full. A word that arrives while the queue is full is dropped and sets `fifo_overflow`, which stays set until reset. A pop while the queue is empty has no effect.
- R9: A word whose unreversed label equals slot i of `match_labels` (bits [8i+7:8i]) is stored in priority slot i instead of the queue. `prio_ready[i]` rises and `prio_word` bits [32i+31:32i] show the word.
- R10: Each priority slot has a readable stage and a back stage. A capture while the readable stage is unread waits in the back stage, and a newer capture overwrites it. After `prio_pop[i]`, the back stage moves to the readable stage; with no back word, `prio_ready[i]` clears.
- R11: `word_irq` pulses for exactly one clock for each word stored in the queue or a slot. It gives no pulse before bit 32 of that word has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_a | input | 1 | Thresholded line A (high means a one symbol) |
| line_b | input | 1 | Thresholded line B (high means a zero symbol) |
| cfg_label_flip | input | 1 | Bit-reverse the label byte of queued words |
| cfg_parity_en | input | 1 | Check bit 32 as odd parity |
| tbl_we | input | 1 | Write strobe for the acceptance table |
| tbl_addr | input | 8 | Label whose table entry is written |
| tbl_bit | input | 1 | Value written: 1 accepts the label |
| match_labels | input | 8*N_PRIO | Priority labels, slot i in bits [8i+7:8i] |
| fifo_pop | input | 1 | Remove the head word of the queue |
| fifo_word | output | 32 | Head word of the queue |
| fifo_empty | output | 1 | Queue holds no word |
| fifo_full | output | 1 | Queue holds FIFO_DEPTH words |
| fifo_overflow | output | 1 | Sticky: a word was dropped on a full queue |
| prio_pop | input | N_PRIO | Release the readable word of each slot |
| prio_word | output | 32*N_PRIO | Readable word of each slot, slot i in bits [32i+31:32i] |
| prio_ready | output | N_PRIO | Slot holds an unread word |
| word_irq | output | 1 | One-clock pulse per stored word |

## Verification
The hardest cases to reach are framing failures inside a word that otherwise completes. One is a both-high symbol placed between correctly timed bits so that the bit count still reaches 32. The other is a gap that ends a partial word just before a valid one. The bench shapes each symbol bit by bit and can stop a word at any bit and then resume it, which reaches both cases. It also fills the queue past its depth, and it stacks three captures on one priority slot so that the overwrite of the back stage can be seen.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  localparam int WORD_W  = 32;
  localparam int LABEL_W = 8;

  typedef enum logic [1:0] {
    SYM_NULL = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_ZERO = 2'd2,
    SYM_BAD  = 2'd3
  } sym_t;

  function automatic logic [LABEL_W-1:0] rev_label(input logic [LABEL_W-1:0] v);
    logic [LABEL_W-1:0] r;
    for (int i = 0; i < LABEL_W; i++) r[i] = v[LABEL_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/a429_bit_decoder.sv
module a429_bit_decoder
  import a429_rx_pkg::*;
#(
  parameter int GAP_CYC = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_a,
  input  logic              line_b,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_out,
  output logic              word_err
);
  localparam int NW = $clog2(GAP_CYC + 1);
  localparam int CW = $clog2(WORD_W);

  logic [1:0] a_sync, b_sync;
  sym_t       sym_now, sym_q;
  logic [CW-1:0] bit_cnt;
  logic [NW-1:0] null_cnt;
  logic [WORD_W-1:0] shreg, shnext;
  logic err_q, start, bitval;

  always_comb begin
    case ({a_sync[1], b_sync[1]})
      2'b10:   sym_now = SYM_ONE;
      2'b01:   sym_now = SYM_ZERO;
      2'b11:   sym_now = SYM_BAD;
      default: sym_now = SYM_NULL;
    endcase
    start  = (sym_q == SYM_NULL) && (sym_now == SYM_ONE || sym_now == SYM_ZERO);
    bitval = (sym_now == SYM_ONE);
    shnext = {bitval, shreg[WORD_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sync     <= '0;
      b_sync     <= '0;
      sym_q      <= SYM_NULL;
      bit_cnt    <= '0;
      null_cnt   <= '0;
      shreg      <= '0;
      err_q      <= 1'b0;
      word_valid <= 1'b0;
      word_out   <= '0;
      word_err   <= 1'b0;
    end else begin
      a_sync     <= {a_sync[0], line_a};
      b_sync     <= {b_sync[0], line_b};
      sym_q      <= sym_now;
      word_valid <= 1'b0;
      if (sym_now == SYM_NULL) begin
        if (null_cnt != NW'(GAP_CYC)) null_cnt <= null_cnt + 1'b1;
      end else begin
        null_cnt <= '0;
      end
      if (sym_now == SYM_BAD) err_q <= 1'b1;
      if (start) begin
        shreg <= shnext;
        if (bit_cnt == CW'(WORD_W - 1)) begin
          word_valid <= 1'b1;
          word_out   <= {shnext[WORD_W-1:LABEL_W], rev_label(shnext[LABEL_W-1:0])};
          word_err   <= err_q;
          bit_cnt    <= '0;
          err_q      <= 1'b0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (sym_now == SYM_NULL && null_cnt == NW'(GAP_CYC - 1)) begin
        bit_cnt <= '0;
        err_q   <= 1'b0;
      end
    end
  end

  // R11: a finished word is announced for one clock only
  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);
endmodule

// File: rtl/a429_word_sort.sv
module a429_word_sort
  import a429_rx_pkg::*;
#(
  parameter int N_PRIO = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [WORD_W-1:0]         in_word,
  input  logic                      in_err,
  input  logic                      cfg_label_flip,
  input  logic                      cfg_parity_en,
  input  logic                      tbl_we,
  input  logic [LABEL_W-1:0]        tbl_addr,
  input  logic                      tbl_bit,
  input  logic [LABEL_W*N_PRIO-1:0] match_labels,
  output logic                      fifo_we,
  output logic [WORD_W-1:0]         fifo_wdata,
  output logic [N_PRIO-1:0]         prio_we,
  output logic [WORD_W-1:0]         prio_wdata,
  output logic                      irq
);
  localparam int TBL_N = 1 << LABEL_W;

  logic tbl_mem [TBL_N];
  logic s1_v, s1_err, s1_par_ok, s1_tbl;
  logic [WORD_W-1:0] s1_word;
  logic [N_PRIO-1:0] hit;
  logic word_ok;

  always_ff @(posedge clk) begin
    if (tbl_we) tbl_mem[tbl_addr] <= tbl_bit;
    if (in_valid) s1_tbl <= tbl_mem[in_word[LABEL_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s1_err    <= 1'b0;
      s1_par_ok <= 1'b0;
      s1_word   <= '0;
      irq       <= 1'b0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_word   <= in_word;
        s1_err    <= in_err;
        s1_par_ok <= !cfg_parity_en || (^in_word);
      end
      irq <= word_ok && ((|hit) || s1_tbl);
    end
  end

  for (genvar i = 0; i < N_PRIO; i++) begin : g_match
    assign hit[i] = (match_labels[LABEL_W*i +: LABEL_W] == s1_word[LABEL_W-1:0]);
  end

  assign word_ok    = s1_v && !s1_err && s1_par_ok;
  assign prio_we    = {N_PRIO{word_ok}} & hit;
  assign prio_wdata = s1_word;
  assign fifo_we    = word_ok && !(|hit) && s1_tbl;
  assign fifo_wdata = cfg_label_flip
                    ? {s1_word[WORD_W-1:LABEL_W], rev_label(s1_word[LABEL_W-1:0])}
                    : s1_word;
endmodule

// File: rtl/a429_rx_fifo.sv
module a429_rx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_addr;
  logic [CNTW-1:0] count, count_n;
  logic push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    push_ok = we && (count != CNTW'(DEPTH));
    pop_ok  = pop && (count != '0);
    rd_addr = pop_ok ? ptr_inc(rd_ptr) : rd_ptr;
    count_n = count + CNTW'(push_ok) - CNTW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
    if (push_ok && wr_ptr == rd_addr) rdata <= wdata;
    else                              rdata <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      empty    <= 1'b1;
      full     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      rd_ptr   <= rd_addr;
      count    <= count_n;
      empty    <= (count_n == '0);
      full     <= (count_n == CNTW'(DEPTH));
      if (we && !push_ok) overflow <= 1'b1;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    count <= CNTW'(DEPTH));
  assert_full_not_empty_R8: assert property (@(posedge clk) disable iff (rst)
    full |-> !empty);
  assert_sticky_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

// File: rtl/a429_prio_slot.sv
module a429_prio_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] cap_data,
  input  logic         pop,
  output logic [W-1:0] front_d,
  output logic         front_v
);
  logic [W-1:0] back_d;
  logic back_v, front_free;

  assign front_free = !front_v || pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      front_d <= '0;
      front_v <= 1'b0;
      back_d  <= '0;
      back_v  <= 1'b0;
    end else begin
      if (front_free && back_v) begin
        front_d <= back_d;
        front_v <= 1'b1;
      end else if (pop) begin
        front_v <= 1'b0;
      end
      if (cap) begin
        back_d <= cap_data;
        back_v <= 1'b1;
      end else if (front_free && back_v) begin
        back_v <= 1'b0;
      end
    end
  end

  // R10: the readable word only disappears after it was popped
  assert_front_kept_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(front_v) |-> $past(pop));
endmodule

// File: rtl/a429_label_rx.sv
module a429_label_rx
  import a429_rx_pkg::*;
#(
  parameter int GAP_CYC    = 48,
  parameter int FIFO_DEPTH = 32,
  parameter int N_PRIO     = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      line_a,
  input  logic                      line_b,
  input  logic                      cfg_label_flip,
  input  logic                      cfg_parity_en,
  input  logic                      tbl_we,
  input  logic [LABEL_W-1:0]        tbl_addr,
  input  logic                      tbl_bit,
  input  logic [LABEL_W*N_PRIO-1:0] match_labels,
  input  logic                      fifo_pop,
  output logic [WORD_W-1:0]         fifo_word,
  output logic                      fifo_empty,
  output logic                      fifo_full,
  output logic                      fifo_overflow,
  input  logic [N_PRIO-1:0]         prio_pop,
  output logic [WORD_W*N_PRIO-1:0]  prio_word,
  output logic [N_PRIO-1:0]         prio_ready,
  output logic                      word_irq
);
  logic              dec_valid, dec_err;
  logic [WORD_W-1:0] dec_word;
  logic              f_we;
  logic [WORD_W-1:0] f_wdata, p_wdata;
  logic [N_PRIO-1:0] p_we;

  a429_bit_decoder #(.GAP_CYC(GAP_CYC)) u_dec (
    .clk(clk), .rst(rst), .line_a(line_a), .line_b(line_b),
    .word_valid(dec_valid), .word_out(dec_word), .word_err(dec_err)
  );

  a429_word_sort #(.N_PRIO(N_PRIO)) u_sort (
    .clk(clk), .rst(rst), .in_valid(dec_valid), .in_word(dec_word), .in_err(dec_err),
    .cfg_label_flip(cfg_label_flip), .cfg_parity_en(cfg_parity_en),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_bit(tbl_bit),
    .match_labels(match_labels), .fifo_we(f_we), .fifo_wdata(f_wdata),
    .prio_we(p_we), .prio_wdata(p_wdata), .irq(word_irq)
  );

  a429_rx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .we(f_we), .wdata(f_wdata), .pop(fifo_pop),
    .rdata(fifo_word), .empty(fifo_empty), .full(fifo_full), .overflow(fifo_overflow)
  );

  for (genvar i = 0; i < N_PRIO; i++) begin : g_slot
    a429_prio_slot #(.W(WORD_W)) u_slot (
      .clk(clk), .rst(rst), .cap(p_we[i]), .cap_data(p_wdata), .pop(prio_pop[i]),
      .front_d(prio_word[WORD_W*i +: WORD_W]), .front_v(prio_ready[i])
    );
  end

  // R11: every pulse follows a completed word two clocks earlier
  assert_irq_after_word_R11: assert property (@(posedge clk) disable iff (rst)
    word_irq |-> $past(dec_valid, 2));
endmodule

// File: tb/test_a429_label_rx.sv
module test_a429_label_rx;
  localparam int HI = 4;
  localparam int LO = 4;
  localparam int IDLE = 60;

  logic clk = 0, rst = 1;
  logic line_a = 0, line_b = 0, cfg_label_flip = 0, cfg_parity_en = 1;
  logic tbl_we = 0, tbl_bit = 0;
  logic [7:0] tbl_addr = 0;
  logic [23:0] match_labels = {8'h07, 8'h3C, 8'hA1};
  logic fifo_pop = 0;
  logic [2:0] prio_pop = 0;
  logic [31:0] fifo_word;
  logic fifo_empty, fifo_full, fifo_overflow, word_irq;
  logic [95:0] prio_word;
  logic [2:0] prio_ready;

  int checks = 0, fails = 0, irq_cnt = 0;

  always #4 clk = ~clk;
  always @(posedge clk) if (word_irq) irq_cnt++;

  a429_label_rx i_a429_label_rx (
    .clk(clk), .rst(rst), .line_a(line_a), .line_b(line_b),
    .cfg_label_flip(cfg_label_flip), .cfg_parity_en(cfg_parity_en),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_bit(tbl_bit),
    .match_labels(match_labels), .fifo_pop(fifo_pop), .fifo_word(fifo_word),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_overflow(fifo_overflow),
    .prio_pop(prio_pop), .prio_word(prio_word), .prio_ready(prio_ready),
    .word_irq(word_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] flip8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [7:0] lbl, input logic [22:0] d);
    logic [30:0] t;
    t = {d, lbl};
    return {~^t, t};
  endfunction

  function automatic logic bit_of(input logic [31:0] w, input int k);
    return (k <= 8) ? w[8-k] : w[k-1];
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_range(input logic [31:0] w, input int first, input int last);
    for (int k = first; k <= last; k++) begin
      @(negedge clk);
      line_a = bit_of(w, k);
      line_b = !bit_of(w, k);
      idle(HI);
      line_a = 0; line_b = 0;
      idle(LO - 1);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    send_range(w, 1, 32);
    idle(IDLE);
  endtask

  task automatic pop_fifo;
    @(negedge clk); fifo_pop = 1;
    @(negedge clk); fifo_pop = 0;
  endtask

  task automatic pop_prio(input int s);
    @(negedge clk); prio_pop[s] = 1;
    @(negedge clk); prio_pop[s] = 0;
    idle(3);
  endtask

  task automatic t_reset;
    check("R1 empty", 32'(fifo_empty), 1);
    check("R1 full", 32'(fifo_full), 0);
    check("R1 overflow", 32'(fifo_overflow), 0);
    check("R1 prio_ready", 32'(prio_ready), 0);
    check("R1 irq", 32'(word_irq), 0);
  endtask

  task automatic t_basic;
    logic [31:0] w1, w2;
    w1 = mk(8'h12, 23'h5A5A5A);
    w2 = mk(8'hF0, 23'h000F31);
    send_word(w1);
    check("R2 stored", 32'(fifo_empty), 0);
    check("R2 word1", fifo_word, w1);
    pop_fifo; idle(2);
    check("R2 drained", 32'(fifo_empty), 1);
    send_word(w2);
    check("R2 word2", fifo_word, w2);
    pop_fifo; idle(2);
  endtask

  task automatic t_irq;
    logic [31:0] w;
    int base;
    w = mk(8'h21, 23'h123456);
    base = irq_cnt;
    send_range(w, 1, 31);
    idle(10);
    check("R11 no pulse before bit 32", irq_cnt, base);
    send_range(w, 32, 32);
    idle(12);
    check("R11 one pulse", irq_cnt, base + 1);
    check("R11 word", fifo_word, w);
    pop_fifo; idle(IDLE);
  endtask

  task automatic t_flip;
    logic [31:0] w, p;
    w = mk(8'h2D, 23'h7F00AA);
    p = mk(8'hA1, 23'h0BEEF1);
    cfg_label_flip = 1;
    send_word(w);
    check("R3 flipped label", fifo_word, {w[31:8], flip8(w[7:0])});
    pop_fifo;
    send_word(p);
    check("R3 prio match under flip", 32'(prio_ready[0]), 1);
    check("R3 prio label unflipped", prio_word[31:0], p);
    check("R3 not queued", 32'(fifo_empty), 1);
    pop_prio(0);
    cfg_label_flip = 0;
  endtask

  task automatic t_table;
    int base;
    base = irq_cnt;
    send_word(mk(8'h55, 23'h111111));
    check("R4 disabled label not queued", 32'(fifo_empty), 1);
    check("R4 no pulse", irq_cnt, base);
  endtask

  task automatic t_parity;
    logic [31:0] bad;
    bad = mk(8'h33, 23'h0F0F0F) ^ 32'h8000_0000;
    send_word(bad);
    check("R5 even parity dropped", 32'(fifo_empty), 1);
    cfg_parity_en = 0;
    send_word(bad);
    check("R5 parity off stored", fifo_word, bad);
    pop_fifo;
    cfg_parity_en = 1;
    idle(2);
  endtask

  task automatic t_gap;
    logic [31:0] w, w2;
    w = mk(8'h44, 23'h3FFFFF);
    w2 = mk(8'h45, 23'h2A0001);
    send_range(w, 1, 10);
    idle(100);
    send_word(w2);
    check("R6 only full word", fifo_word, w2);
    pop_fifo; idle(2);
    check("R6 partial discarded", 32'(fifo_empty), 1);
  endtask

  task automatic t_both;
    logic [31:0] w, w2;
    w = mk(8'h46, 23'h055555);
    w2 = mk(8'h47, 23'h600006);
    send_range(w, 1, 5);
    @(negedge clk); line_a = 1; line_b = 1;
    idle(HI); line_a = 0; line_b = 0;
    idle(LO);
    send_range(w, 6, 32);
    idle(IDLE);
    check("R7 both-high word dropped", 32'(fifo_empty), 1);
    send_word(w2);
    check("R7 next word fine", fifo_word, w2);
    pop_fifo; idle(2);
  endtask

  task automatic t_fifo;
    logic [31:0] extra;
    for (int i = 0; i < 32; i++) send_word(mk(8'h80 + 8'(i), 23'(i * 977 + 5)));
    check("R8 full", 32'(fifo_full), 1);
    check("R8 no overflow yet", 32'(fifo_overflow), 0);
    extra = mk(8'hA0, 23'h7ABCDE);
    send_word(extra);
    check("R8 overflow set", 32'(fifo_overflow), 1);
    for (int i = 0; i < 32; i++) begin
      check("R8 order", fifo_word, mk(8'h80 + 8'(i), 23'(i * 977 + 5)));
      pop_fifo;
    end
    idle(2);
    check("R8 empty after drain", 32'(fifo_empty), 1);
    check("R8 overflow sticky", 32'(fifo_overflow), 1);
    pop_fifo; idle(2);
    check("R8 pop on empty", 32'(fifo_empty), 1);
    check("R8 pop on empty not full", 32'(fifo_full), 0);
    send_word(mk(8'h11, 23'h000777));
    check("R8 after empty pop", fifo_word, mk(8'h11, 23'h000777));
    pop_fifo; idle(2);
    check("R8 single word popped", 32'(fifo_empty), 1);
  endtask

  task automatic t_prio;
    logic [31:0] p1, p2, p3, q;
    p1 = mk(8'h3C, 23'h000001);
    p2 = mk(8'h3C, 23'h000002);
    p3 = mk(8'h3C, 23'h000003);
    q  = mk(8'h07, 23'h4C4C4C);
    send_word(p1);
    check("R9 slot1 ready", 32'(prio_ready), 32'b010);
    check("R9 slot1 word", prio_word[63:32], p1);
    check("R9 bypasses queue", 32'(fifo_empty), 1);
    send_word(p2);
    send_word(p3);
    check("R10 front kept", prio_word[63:32], p1);
    pop_prio(1);
    check("R10 back moved, newest kept", prio_word[63:32], p3);
    check("R10 still ready", 32'(prio_ready[1]), 1);
    pop_prio(1);
    check("R10 cleared", 32'(prio_ready[1]), 0);
    send_word(q);
    check("R9 slot2 word", prio_word[95:64], q);
    check("R9 slot2 ready only", 32'(prio_ready), 32'b100);
    pop_prio(2);
  endtask

  initial begin
    idle(5);
    rst = 0;
    idle(1);
    t_reset;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      tbl_we = 1; tbl_addr = 8'(a); tbl_bit = (a != 8'h55);
    end
    @(negedge clk); tbl_we = 0;
    idle(IDLE);
    t_basic;
    t_irq;
    t_flip;
    t_table;
    t_parity;
    t_gap;
    t_both;
    t_prio;
    t_fifo;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule